// File: doc/BRIEF.md
# Attribute Register Port with Shared Index/Data Address

This block holds a small file of colour-palette and display-control registers behind a minimal register bus. Software reaches every register through one write address. A one-bit toggle decides how each write to that address is taken. In the index phase the byte picks a register. In the data phase the byte is stored into the register that was picked. Reading a separate status address returns the toggle to the index phase. Driver code uses this read to reach a known starting point before a sequence of accesses.

The index byte also carries a display-enable bit in bit 5. While that bit is clear the palette is detached from the display, so software can rewrite it without visible artefacts. An index written with bit 5 set hands the palette back to the display. All register contents are presented in parallel on a flat output bus for the video pipeline.

The toggle is a two-state machine. `PH_INDEX` means the next shared write is an index. `PH_DATA` means the next shared write is data. It has three named transitions. `T_CAPTURE` goes from `PH_INDEX` to `PH_DATA` on a shared write. `T_STORE` goes from `PH_DATA` to `PH_INDEX` on a shared write. `T_CLEAR` goes from either state to `PH_INDEX` on a status read, and it takes priority over the other two.

Top module: `attr_port`

## Requirements
- R1: After reset the phase is index, the stored index is 0, every register is 0 and `disp_en` is 0.
- R2: A write to address 0 in the index phase stores `wr_data[5:0]` as the index and moves the phase to data. Bits 7:6 are discarded.
- R3: A write to address 0 in the data phase stores `wr_data` into register `index[4:0]` and returns the phase to index. Registers 0..15 are palette entries and 16..20 are control registers. Register k occupies `reg_bus[8k+7:8k]`.
- R4: A data-phase write whose `index[4:0]` is 21 or above changes no register, but it still returns the phase to index.
- R5: A read of address 2 (status) returns `{6'b0, disp_en, phase}`, where phase 1 means data. The phase is index on the following cycle, whatever it was before.
- R6: `disp_en` equals bit 5 of the most recent index write. Data-phase writes leave it unchanged.
- R7: A read of address 0 returns `{2'b0, index}` and leaves the phase unchanged.
- R8: A read of address 1 returns the register selected by `index[4:0]`, or 0 for an unimplemented index. It leaves the phase unchanged.
- R9: Read data appears on `rd_data` with `rd_valid` high exactly one cycle after `rd_en`. `rd_valid` is never high otherwise.
- R10: When a status read and a write to address 0 occur in the same cycle, the write is taken according to the phase before that cycle, and the phase ends in index.
- R11: Writes to address 3 change nothing. Reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0 shared, others no effect) |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address (0 index, 1 data, 2 status, 3 none) |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| disp_en | output | 1 | Palette drives the display when high |
| reg_bus | output | 168 | All 21 registers, register k at bits 8k+7:8k |

## Verification
The assertions watch the toggle on every cycle:
- it sets after an index write,
- it clears after a data write or a status read,
- `disp_en` moves only on index writes,
- out-of-range data writes leave the register bus still,
- reads return exactly one cycle later.

Only the bench scenarios can show three further behaviours. The first is that the right byte lands in the right register across all 21 slots. The second is that a status read reports the phase as it stood before it cleared it. The third is the combined outcome of a status read that collides with a shared write.

// File: rtl/attr_port_pkg.sv
package attr_port_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_SHARED = 2'd0;
    localparam logic [ADDR_W-1:0] A_DATA   = 2'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;

    typedef enum logic {
        PH_INDEX = 1'b0,
        PH_DATA  = 1'b1
    } phase_t;
endpackage

// File: rtl/attr_phase_fsm.sv
module attr_phase_fsm
    import attr_port_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   shared_wr,
    input  logic   status_rd,
    output phase_t phase,
    output logic   idx_load,
    output logic   data_load
);
    phase_t state_q, state_d;

    // next state: T_CAPTURE, T_STORE, then T_CLEAR overrides
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_INDEX: if (shared_wr) state_d = PH_DATA;   // T_CAPTURE
            PH_DATA:  if (shared_wr) state_d = PH_INDEX;  // T_STORE
            default:  state_d = PH_INDEX;
        endcase
        if (status_rd) state_d = PH_INDEX;                // T_CLEAR
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_INDEX;
        else        state_q <= state_d;
    end

    always_comb begin
        idx_load  = 1'b0;
        data_load = 1'b0;
        unique case (state_q)
            PH_INDEX: idx_load  = shared_wr;
            PH_DATA:  data_load = shared_wr;
            default: ;
        endcase
    end

    assign phase = state_q;
endmodule

// File: rtl/attr_index_reg.sv
module attr_index_reg #(
    parameter int IDX_W = 6,
    parameter int EN_BIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] din,
    output logic [IDX_W-1:0] idx,
    output logic             disp_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    idx <= '0;
        else if (load) idx <= din;
    end

    assign disp_en = idx[EN_BIT];
endmodule

// File: rtl/attr_reg_bank.sv
module attr_reg_bank #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 21,
    parameter int SEL_W    = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [SEL_W-1:0]           sel,
    input  logic [DATA_W-1:0]          din,
    output logic [NUM_REGS*DATA_W-1:0] bank_flat,
    output logic [DATA_W-1:0]          sel_q
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[k] <= '0;
            else if (we && (sel == SEL_W'(k)))
                regs[k] <= din;
        end
        assign bank_flat[k*DATA_W +: DATA_W] = regs[k];
    end

    always_comb begin
        sel_q = '0;
        for (int k = 0; k < NUM_REGS; k++)
            if (sel == SEL_W'(k)) sel_q = regs[k];
    end
endmodule

// File: rtl/attr_read_port.sv
module attr_read_port
    import attr_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] reg_val,
    input  logic              disp_en,
    input  phase_t            phase,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [DATA_W-1:0] mux_d;

    always_comb begin
        mux_d = '0;
        unique case (rd_addr)
            A_SHARED: mux_d = DATA_W'(idx);
            A_DATA:   mux_d = reg_val;
            A_STATUS: mux_d = DATA_W'({disp_en, phase == PH_DATA});
            default:  mux_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= mux_d;
        end
    end
endmodule

// File: rtl/attr_port.sv
module attr_port
    import attr_port_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_PAL  = 16,
    parameter int NUM_CTRL = 5,
    parameter int EN_BIT   = 5
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [1:0]                            wr_addr,
    input  logic [DATA_W-1:0]                     wr_data,
    input  logic                                  rd_en,
    input  logic [1:0]                            rd_addr,
    output logic [DATA_W-1:0]                     rd_data,
    output logic                                  rd_valid,
    output logic                                  disp_en,
    output logic [(NUM_PAL+NUM_CTRL)*DATA_W-1:0]  reg_bus
);
    localparam int NUM_REGS = NUM_PAL + NUM_CTRL;
    localparam int SEL_W    = EN_BIT;
    localparam int IDX_W    = EN_BIT + 1;

    logic             shared_wr, status_rd, idx_load, data_load, sel_ok;
    phase_t           phase_q;
    logic [IDX_W-1:0] index_q;
    logic [DATA_W-1:0] sel_val;

    assign shared_wr = wr_en && (wr_addr == A_SHARED);
    assign status_rd = rd_en && (rd_addr == A_STATUS);
    assign sel_ok    = index_q[SEL_W-1:0] < SEL_W'(NUM_REGS);

    attr_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .shared_wr(shared_wr), .status_rd(status_rd),
        .phase(phase_q), .idx_load(idx_load), .data_load(data_load)
    );

    attr_index_reg #(.IDX_W(IDX_W), .EN_BIT(EN_BIT)) u_idx (
        .clk(clk), .rst_n(rst_n), .load(idx_load),
        .din(wr_data[IDX_W-1:0]), .idx(index_q), .disp_en(disp_en)
    );

    attr_reg_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(data_load && sel_ok),
        .sel(index_q[SEL_W-1:0]), .din(wr_data),
        .bank_flat(reg_bus), .sel_q(sel_val)
    );

    attr_read_port #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .idx(index_q), .reg_val(sel_val), .disp_en(disp_en), .phase(phase_q),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/attr_port_chk.sv
module attr_port_chk
    import attr_port_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 21,
    parameter int IDX_W    = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [1:0]                 wr_addr,
    input logic [IDX_W-1:0]           wr_low,
    input logic                       rd_en,
    input logic [1:0]                 rd_addr,
    input logic [DATA_W-1:0]          rd_data,
    input logic                       rd_valid,
    input logic                       disp_en,
    input phase_t                     phase,
    input logic [IDX_W-1:0]           index,
    input logic [NUM_REGS*DATA_W-1:0] reg_bus
);
    logic sh_wr, st_rd, hi_sel;
    assign sh_wr  = wr_en && wr_addr == A_SHARED;
    assign st_rd  = rd_en && rd_addr == A_STATUS;
    assign hi_sel = index[IDX_W-2:0] >= (IDX_W-1)'(NUM_REGS);

    a_r2_capture_sets_phase: assert property (@(posedge clk) disable iff (!rst_n)
        sh_wr && phase == PH_INDEX && !st_rd |=> phase == PH_DATA);

    a_r2_index_captured: assert property (@(posedge clk) disable iff (!rst_n)
        sh_wr && phase == PH_INDEX |=> index == $past(wr_low));

    a_r3_store_clears_phase: assert property (@(posedge clk) disable iff (!rst_n)
        sh_wr && phase == PH_DATA |=> phase == PH_INDEX);

    a_r4_high_index_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        sh_wr && phase == PH_DATA && hi_sel |=> $stable(reg_bus));

    a_r5_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd |=> phase == PH_INDEX);

    a_r6_enable_follows_index: assert property (@(posedge clk) disable iff (!rst_n)
        sh_wr && phase == PH_INDEX |=> disp_en == $past(wr_low[IDX_W-1]));

    a_r6_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_wr && phase == PH_INDEX) |=> $stable(disp_en));

    a_r7_index_readback: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_addr == A_SHARED |=> rd_data == DATA_W'($past(index)));

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    a_r11_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_addr == 2'd3 |=> rd_data == '0);
endmodule

bind attr_port attr_port_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_low(wr_data[IDX_W-1:0]), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .disp_en(disp_en),
    .phase(phase_q), .index(index_q), .reg_bus(reg_bus)
);

// File: tb/sim_attr_port.sv
module sim_attr_port;
    localparam int NR = 21;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, wr_en, rd_en, rd_valid, disp_en;
    logic [1:0]    wr_addr, rd_addr;
    logic [7:0]    wr_data, rd_data;
    logic [NR*8-1:0] reg_bus;

    attr_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .disp_en(disp_en),
        .reg_bus(reg_bus)
    );

    int checks = 0;
    int fails  = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    // reference state derived from the requirements
    logic [5:0] m_idx;
    logic       m_ph;
    logic [7:0] m_regs [NR];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(logic [1:0] a);
        case (a)
            2'd0: return {2'b0, m_idx};
            2'd1: return (m_idx[4:0] < 5'd21) ? m_regs[m_idx[4:0]] : 8'h00;
            2'd2: return {6'b0, m_idx[5], m_ph};
            default: return 8'h00;
        endcase
    endfunction

    task automatic access(bit we, logic [1:0] wa, logic [7:0] wd,
                          bit re, logic [1:0] ra, string tag);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra;
        if (re) begin
            exp_q.push_back(model_read(ra));
            tag_q.push_back(tag);
        end
        if (we && wa == 2'd0) begin
            if (!m_ph) begin m_idx = wd[5:0]; m_ph = 1'b1; end
            else begin
                if (m_idx[4:0] < 5'd21) m_regs[m_idx[4:0]] = wd;
                m_ph = 1'b0;
            end
        end
        if (re && ra == 2'd2) m_ph = 1'b0;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        access(1'b1, a, d, 1'b0, 2'd0, "");
    endtask

    task automatic rd(logic [1:0] a, string tag);
        access(1'b0, 2'd0, 8'h00, 1'b1, a, tag);
        @(negedge clk);  // let the monitor consume the result
    endtask

    task automatic check_bus(string tag);
        logic [NR*8-1:0] e;
        for (int k = 0; k < NR; k++) e[k*8 +: 8] = m_regs[k];
        checks++;
        if (reg_bus !== e) begin
            fails++;
            $display("FAIL %s reg_bus actual=%0h expected=%0h", tag, reg_bus, e);
        end
    endtask

    // monitor: scoreboard pop on every valid read (R9)
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9 unexpected rd_valid actual=1 expected=0");
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, {24'b0, rd_data}, {24'b0, e});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        wr_addr = '0; rd_addr = '0; wr_data = '0;
        m_idx = '0; m_ph = 1'b0;
        for (int k = 0; k < NR; k++) m_regs[k] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 disp_en", {31'b0, disp_en}, 0);
        check_bus("R1");
        rd(2'd2, "R1 status after reset");
        rd(2'd0, "R1 index after reset");

        // R2 index capture, R5 status reports data phase then clears
        wr(2'd0, 8'hC3);
        rd(2'd0, "R2 index upper bits dropped");
        rd(2'd2, "R5 status shows data phase");
        // R3 data store into register 3
        wr(2'd0, 8'h03);
        wr(2'd0, 8'h2A);
        check_bus("R3 reg3 stored");
        rd(2'd1, "R8 data readback reg3");
        rd(2'd0, "R7 index readback");
        rd(2'd2, "R3 phase back to index");

        // R6 enable bit via index to control register 20
        wr(2'd0, 8'h34);
        check("R6 enable set by index", {31'b0, disp_en}, 1);
        wr(2'd0, 8'h11);
        check("R6 data write keeps enable", {31'b0, disp_en}, 1);
        check_bus("R3 reg20 stored");

        // R4 unimplemented index
        wr(2'd0, 8'h1F);
        check("R6 enable cleared by index", {31'b0, disp_en}, 0);
        wr(2'd0, 8'hFF);
        check_bus("R4 no register change");
        rd(2'd1, "R8 unimplemented reads zero");
        rd(2'd2, "R4 phase back to index");

        // R5 status read cancels pending data phase
        wr(2'd0, 8'h25);
        rd(2'd2, "R5 status with enable and data phase");
        wr(2'd0, 8'h07);
        rd(2'd0, "R5 next write taken as index");
        check("R5 enable from new index", {31'b0, disp_en}, 0);
        rd(2'd2, "R5 phase data after index");

        // R10 collision of status read and data write
        wr(2'd0, 8'h02);
        access(1'b1, 2'd0, 8'h5A, 1'b1, 2'd2, "R10 status before collision");
        @(negedge clk);
        check_bus("R10 data written during collision");
        rd(2'd2, "R10 phase index after collision");

        // R11 address 3
        wr(2'd3, 8'h99);
        rd(2'd3, "R11 read of address 3");
        check_bus("R11 no register change");
        rd(2'd2, "R11 phase unchanged");

        // R3/R8 sweep over all registers
        for (int k = 0; k < NR; k++) begin
            wr(2'd0, 8'(k));
            wr(2'd0, 8'((k * 37 + 5) & 8'hFF));
        end
        check_bus("R3 full sweep");
        for (int k = 0; k < NR; k++) begin
            wr(2'd0, 8'(k));
            rd(2'd1, "R8 sweep readback");
            rd(2'd2, "R5 sweep status clear");
        end

        repeat (3) @(negedge clk);
        check("R9 all reads answered", exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule